// File: doc/BRIEF.md
# Masked Multi-Address I2C Slave Receiver

This block is the receive front end of an I2C target. It watches the SCL and SDA lines and finds START and STOP conditions. After a START it shifts in the address byte and compares the 7-bit address against a set of programmable slots. Each slot holds an address and its own mask, and each slot can also choose to answer the general call address.

When the address matches and acknowledging is enabled, the block pulls SDA low for the acknowledge bit. It then takes in data bytes. At the ninth clock of every frame it takes part in, the block copies the received byte into a read-only snapshot register. A raise flag is set at that point and stays until software clears it.

Software drives the block through two control strobes that share one write data word. One strobe sets bits and the other clears them. A separate port loads the slot addresses and masks.

Top module: `i2cs_multi_rx`

## Requirements
- R1: After reset, `ctl_o`, `rx_buf_o`, every slot address and every slot mask are zero. `match_id_o` is all ones, `addressed_o` is 0 and `sda_pull_o` is 0.
- R2: The control word uses these bit positions: acknowledge enable = bit 2, raise flag = bit 3, abort = bit 4, start-request = bit 5, enable = bit 6. Bits 1:0 always read 0. A set strobe ORs `ctl_wdata` into the word and a clear strobe removes those bits. A zero write to either strobe leaves the word unchanged.
- R3: The address bits are bits 7:1 of the received byte. A slot register holds its address in bits 7:1. A mask bit of 1 makes that address bit a don't-care, and a non-zero address matches a slot when all unmasked bits are equal. If several slots match, the lowest slot index wins, and `match_id_o` reports that index.
- R4: A received address of 0000000 matches only when some slot has bit 0 of its address register set. The masks play no part in this check. `match_id_o` then reads NSLOT (4 by default).
- R5: A received R/W bit of 1 never matches, and the block does not acknowledge it.
- R6: After a matching address, with acknowledge enable set, `sda_pull_o` rises on the SCL fall after the eighth bit and drops on the SCL fall after the ninth. `addressed_o` rises when the eighth bit is sampled. With acknowledge enable clear, the block neither acknowledges nor becomes addressed.
- R7: The raise flag is set at the ninth SCL rise of an acknowledged address frame and of every data frame received while addressed. It stays set until it is cleared through the clear strobe.
- R8: `rx_buf_o` takes the received byte at the ninth SCL rise of each frame the block is addressed in. It is unchanged at all other times.
- R9: While addressed, a data byte is acknowledged when acknowledge enable is set. When the ninth bit is sampled high (NACK), the block returns to not-addressed at the following SCL fall.
- R10: A STOP returns the block to not-addressed. A START, including a repeated START, begins a new address reception and drops `addressed_o`.
- R11: While enable is 0, the bus lines are ignored, the block stays not-addressed with SDA released, and the abort bit reads 0 even if it is written.
- R12: Setting the abort bit while enabled forces the not-addressed state on the next cycle. The bit reads 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 drives SDA low (acknowledge) |
| cfg_we | input | 1 | Write strobe for a slot register |
| cfg_slot | input | SW | Slot index to write |
| cfg_is_mask | input | 1 | 1 writes the mask, 0 writes the address register |
| cfg_wdata | input | 8 | Address register value, or mask in bits 6:0 |
| ctl_set_we | input | 1 | Set strobe for the control word |
| ctl_clr_we | input | 1 | Clear strobe for the control word |
| ctl_wdata | input | 7 | Bit pattern for the set or clear strobe |
| ctl_o | output | 7 | Control word readback |
| rx_buf_o | output | 8 | Snapshot of the last received byte |
| match_id_o | output | IDW | Slot that produced the last match, NSLOT for general call |
| addressed_o | output | 1 | Block is currently addressed |

## Verification
The bench builds the block with NSLOT = 4 and a two-stage synchronizer. With these values `match_id_o` is 3 bits wide: slot IDs 0 to 3, general call 4, and all-ones for no match. The slot programming makes two slots match the same address: a slot with a partial mask and a slot whose mask is all ones. This exercises the lowest-index priority. The same all-ones mask, tried against address zero with the slot's general call bit cleared, shows that masks have no effect on general call matching.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned CTL_W = 7;
  localparam int unsigned B_AA  = 2;
  localparam int unsigned B_SI  = 3;
  localparam int unsigned B_STO = 4;
  localparam int unsigned B_STA = 5;
  localparam int unsigned B_EN  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_DATA,
    ST_ACK_D
  } rx_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_now
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC-2:0], sda_i};
      scl_q  <= scl_ff[SYNC-1];
      sda_q  <= sda_ff[SYNC-1];
    end
  end

  assign scl_s     = scl_ff[SYNC-1];
  assign sda_s     = sda_ff[SYNC-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_now   = sda_s;
endmodule

// File: rtl/i2cs_cfg_regs.sv
module i2cs_cfg_regs #(
  parameter int NSLOT = 4,
  parameter int SW    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SW-1:0]      cfg_slot,
  input  logic               cfg_is_mask,
  input  logic [7:0]         cfg_wdata,
  output logic [NSLOT*8-1:0] addr_flat,
  output logic [NSLOT*7-1:0] mask_flat
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [7:0] addr_q;
    logic [6:0] mask_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
        mask_q <= '0;
      end else if (cfg_we && cfg_slot == SW'(g)) begin
        if (cfg_is_mask) mask_q <= cfg_wdata[6:0];
        else             addr_q <= cfg_wdata;
      end
    end
    assign addr_flat[g*8 +: 8] = addr_q;
    assign mask_flat[g*7 +: 7] = mask_q;
  end
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
  parameter int NSLOT = 4,
  parameter int IDW   = 3
) (
  input  logic [7:0]         rx_byte,
  input  logic [NSLOT*8-1:0] addr_flat,
  input  logic [NSLOT*7-1:0] mask_flat,
  output logic               hit,
  output logic [IDW-1:0]     hit_id
);
  logic [6:0]       rx_a;
  logic             is_gc;
  logic [NSLOT-1:0] slot_hit, gc_en;

  assign rx_a  = rx_byte[7:1];
  assign is_gc = (rx_a == 7'd0);

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign slot_hit[g] = (((rx_a ^ addr_flat[g*8+1 +: 7]) & ~mask_flat[g*7 +: 7]) == 7'd0);
    assign gc_en[g]    = addr_flat[g*8];
  end

  always_comb begin
    hit    = 1'b0;
    hit_id = '1;
    if (!rx_byte[0]) begin
      if (is_gc) begin
        // masks never take part in the general call decision
        if (|gc_en) begin
          hit    = 1'b1;
          hit_id = IDW'(NSLOT);
        end
      end else begin
        for (int i = NSLOT - 1; i >= 0; i--) begin
          if (slot_hit[i]) begin
            hit    = 1'b1;
            hit_id = IDW'(i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_multi_rx.sv
module i2cs_multi_rx
  import i2cs_pkg::*;
#(
  parameter  int NSLOT = 4,
  parameter  int SYNC  = 2,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int IDW   = $clog2(NSLOT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_slot,
  input  logic             cfg_is_mask,
  input  logic [7:0]       cfg_wdata,
  input  logic             ctl_set_we,
  input  logic             ctl_clr_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_o,
  output logic [7:0]       rx_buf_o,
  output logic [IDW-1:0]   match_id_o,
  output logic             addressed_o
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_now;
  logic [NSLOT*8-1:0] addr_flat;
  logic [NSLOT*7-1:0] mask_flat;
  logic               hit;
  logic [IDW-1:0]     hit_id;

  logic [CTL_W-1:0] ctl_q, ctl_nxt;
  rx_state_e        st_q;
  logic [2:0]       cnt_q;
  logic [7:0]       sh_q, buf_q, nxt_byte;
  logic             pull_q, in9_q, nack_q;
  logic [IDW-1:0]   id_q;
  logic             en, aa, sto, run, si_hw, in_ack;

  i2cs_line_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_now(sda_now)
  );

  i2cs_cfg_regs #(.NSLOT(NSLOT), .SW(SW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_is_mask(cfg_is_mask), .cfg_wdata(cfg_wdata),
    .addr_flat(addr_flat), .mask_flat(mask_flat)
  );

  assign nxt_byte = {sh_q[6:0], sda_now};

  i2cs_addr_match #(.NSLOT(NSLOT), .IDW(IDW)) u_match (
    .rx_byte(nxt_byte), .addr_flat(addr_flat), .mask_flat(mask_flat),
    .hit(hit), .hit_id(hit_id)
  );

  assign en     = ctl_q[B_EN];
  assign aa     = ctl_q[B_AA];
  assign sto    = ctl_q[B_STO];
  assign run    = en & ~sto & ~start_det & ~stop_det;
  assign in_ack = (st_q == ST_ACK_A) || (st_q == ST_ACK_D);
  // ninth rising edge of a frame the block takes part in
  assign si_hw  = run & in_ack & in9_q & scl_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      buf_q  <= '0;
      pull_q <= 1'b0;
      in9_q  <= 1'b0;
      nack_q <= 1'b0;
      id_q   <= '1;
    end else if (!en || sto) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      in9_q  <= 1'b0;
    end else if (start_det) begin
      st_q   <= ST_ADDR;
      cnt_q  <= '0;
      pull_q <= 1'b0;
      in9_q  <= 1'b0;
    end else if (stop_det) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      in9_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (scl_rise) begin
          sh_q  <= nxt_byte;
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (hit && aa) begin
              st_q  <= ST_ACK_A;
              id_q  <= hit_id;
              in9_q <= 1'b0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_DATA: if (scl_rise) begin
          sh_q  <= nxt_byte;
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            st_q  <= ST_ACK_D;
            in9_q <= 1'b0;
          end
        end
        ST_ACK_A, ST_ACK_D: begin
          if (scl_fall) begin
            if (!in9_q) begin
              in9_q  <= 1'b1;
              pull_q <= (st_q == ST_ACK_A) ? 1'b1 : aa;
            end else begin
              in9_q  <= 1'b0;
              pull_q <= 1'b0;
              cnt_q  <= '0;
              st_q   <= (st_q == ST_ACK_D && nack_q) ? ST_IDLE : ST_DATA;
            end
          end
          if (scl_rise && in9_q) begin
            buf_q  <= sh_q;
            nack_q <= sda_now;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl_nxt = ctl_q;
    if (ctl_q[B_STO]) ctl_nxt[B_STO] = 1'b0;
    if (ctl_clr_we)   ctl_nxt = ctl_nxt & ~ctl_wdata;
    if (ctl_set_we)   ctl_nxt = ctl_nxt | ctl_wdata;
    if (si_hw)        ctl_nxt[B_SI] = 1'b1;
    if (!ctl_nxt[B_EN]) ctl_nxt[B_STO] = 1'b0;
    ctl_nxt[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_nxt;
  end

  assign ctl_o       = ctl_q;
  assign rx_buf_o    = buf_q;
  assign match_id_o  = id_q;
  assign sda_pull_o  = pull_q;
  assign addressed_o = (st_q == ST_ACK_A) || (st_q == ST_DATA) || (st_q == ST_ACK_D);
endmodule

// File: rtl/i2cs_multi_rx_chk.sv
module i2cs_multi_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] ctl_o,
  input logic       ctl_set_we,
  input logic       ctl_clr_we,
  input logic [6:0] ctl_wdata,
  input logic       sda_pull_o,
  input logic       addressed_o,
  input logic [7:0] rx_buf_o
);
  p_pull_needs_addr_r6: assert property (@(posedge clk) disable iff (rst)
    sda_pull_o |-> addressed_o);

  p_off_goes_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !ctl_o[6] |=> (!addressed_o && !sda_pull_o));

  p_off_no_abort_r11: assert property (@(posedge clk) disable iff (rst)
    !ctl_o[6] |-> !ctl_o[4]);

  p_abort_one_cycle_r12: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[4] && !(ctl_set_we && ctl_wdata[4])) |=> !ctl_o[4]);

  p_abort_drops_addr_r12: assert property (@(posedge clk) disable iff (rst)
    ctl_o[4] |=> !addressed_o);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[3] && !(ctl_clr_we && ctl_wdata[3])) |=> ctl_o[3]);

  p_buf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !addressed_o |=> $stable(rx_buf_o));
endmodule

bind i2cs_multi_rx i2cs_multi_rx_chk u_chk (
  .clk(clk), .rst(rst), .ctl_o(ctl_o), .ctl_set_we(ctl_set_we),
  .ctl_clr_we(ctl_clr_we), .ctl_wdata(ctl_wdata), .sda_pull_o(sda_pull_o),
  .addressed_o(addressed_o), .rx_buf_o(rx_buf_o)
);

// File: tb/i2cs_multi_rx_tb.sv
module i2cs_multi_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic       scl_m, sda_m;
  wire        sda_i;
  logic       sda_pull_o;
  logic       cfg_we, cfg_is_mask;
  logic [1:0] cfg_slot;
  logic [7:0] cfg_wdata;
  logic       ctl_set_we, ctl_clr_we;
  logic [6:0] ctl_wdata, ctl_o;
  logic [7:0] rx_buf_o;
  logic [2:0] match_id_o;
  logic       addressed_o;

  int n_vec = 0;
  int n_bad = 0;

  bit         m_en, m_aa, m_si, m_sta, m_addr, m_pull;
  logic [7:0] m_buf;
  logic [2:0] m_id;
  logic [7:0] m_slot [4];
  logic [6:0] m_mask [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_i = sda_m & ~sda_pull_o;

  i2cs_multi_rx u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_i), .sda_pull_o(sda_pull_o),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_is_mask(cfg_is_mask), .cfg_wdata(cfg_wdata),
    .ctl_set_we(ctl_set_we), .ctl_clr_we(ctl_clr_we), .ctl_wdata(ctl_wdata),
    .ctl_o(ctl_o), .rx_buf_o(rx_buf_o), .match_id_o(match_id_o), .addressed_o(addressed_o)
  );

  task automatic check(input string tag);
    logic [6:0] ec;
    ec = {m_en, m_sta, 1'b0, m_si, m_aa, 2'b00};
    n_vec++;
    if (ctl_o !== ec || rx_buf_o !== m_buf || match_id_o !== m_id ||
        addressed_o !== m_addr || sda_pull_o !== m_pull) begin
      n_bad++;
      $display("FAIL %s ctl=%h/%h buf=%h/%h id=%0d/%0d addr=%b/%b pull=%b/%b", tag,
               ctl_o, ec, rx_buf_o, m_buf, match_id_o, m_id, addressed_o, m_addr,
               sda_pull_o, m_pull);
    end
  endtask

  task automatic expect1(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s got %b want %b", tag, act, exp);
    end
  endtask

  function automatic int mdl_match(input logic [7:0] b);
    if (b[0]) return -1;
    if (b[7:1] == 7'd0) begin
      for (int k = 0; k < 4; k++) if (m_slot[k][0]) return 4;
      return -1;
    end
    for (int k = 0; k < 4; k++)
      if (((b[7:1] ^ m_slot[k][7:1]) & ~m_mask[k]) == 7'd0) return k;
    return -1;
  endfunction

  task automatic bus(input logic s, input logic d, input string tag);
    @(negedge clk);
    scl_m = s;
    sda_m = d;
    repeat (SETTLE) @(negedge clk);
    check(tag);
  endtask

  task automatic start_c(input string tag);
    bus(1'b0, 1'b1, tag);
    bus(1'b1, 1'b1, tag);
    m_addr = 1'b0;
    bus(1'b1, 1'b0, tag);
    bus(1'b0, 1'b0, tag);
  endtask

  task automatic stop_c(input string tag);
    bus(1'b0, 1'b0, tag);
    bus(1'b1, 1'b0, tag);
    m_addr = 1'b0;
    bus(1'b1, 1'b1, tag);
  endtask

  task automatic frame(input logic [7:0] b, input bit is_addr, input string tag);
    bit live, ack;
    int id;
    live = 1'b0;
    ack  = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bus(1'b0, b[i], tag);
      if (i == 0) begin
        if (is_addr) begin
          id = mdl_match(b);
          if (m_en && m_aa && id >= 0) begin
            live = 1'b1; ack = 1'b1;
            m_addr = 1'b1;
            m_id = 3'(id);
          end
        end else if (m_addr) begin
          live = 1'b1;
          ack  = m_aa;
        end
      end
      bus(1'b1, b[i], tag);
    end
    m_pull = live && ack;
    bus(1'b0, 1'b1, tag);
    if (live) begin
      m_buf = b;
      m_si  = 1'b1;
    end
    bus(1'b1, 1'b1, tag);
    m_pull = 1'b0;
    if (live && !ack) m_addr = 1'b0;
    bus(1'b0, 1'b1, tag);
  endtask

  task automatic ctl_set(input logic [6:0] v, input string tag);
    @(negedge clk);
    ctl_set_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_set_we = 1'b0; ctl_wdata = '0;
    m_en |= v[6]; m_sta |= v[5]; m_si |= v[3]; m_aa |= v[2];
    check(tag);
  endtask

  task automatic ctl_clr(input logic [6:0] v, input string tag);
    @(negedge clk);
    ctl_clr_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_clr_we = 1'b0; ctl_wdata = '0;
    if (v[6]) m_en = 1'b0;
    if (v[5]) m_sta = 1'b0;
    if (v[3]) m_si = 1'b0;
    if (v[2]) m_aa = 1'b0;
    check(tag);
  endtask

  task automatic cfg(input int s, input bit is_mask, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 2'(s); cfg_is_mask = is_mask; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (is_mask) m_mask[s] = d[6:0];
    else         m_slot[s] = d;
    check("R3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    cfg_we = 1'b0; cfg_slot = '0; cfg_is_mask = 1'b0; cfg_wdata = '0;
    ctl_set_we = 1'b0; ctl_clr_we = 1'b0; ctl_wdata = '0;
    m_en = 0; m_aa = 0; m_si = 0; m_sta = 0; m_addr = 0; m_pull = 0;
    m_buf = '0; m_id = 3'd7;
    for (int k = 0; k < 4; k++) begin m_slot[k] = '0; m_mask[k] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1");

    // R2: set / clear word, zero writes ignored
    ctl_set(7'h44, "R2");
    ctl_set(7'h00, "R2");
    ctl_set(7'h20, "R2");
    ctl_clr(7'h00, "R2");
    ctl_clr(7'h20, "R2");

    // slot programming: overlapping slot1 and all-masked slot3
    cfg(0, 1'b0, 8'hA0);
    cfg(1, 1'b0, 8'h60);
    cfg(1, 1'b1, 8'h0F);
    cfg(3, 1'b0, 8'h25);
    cfg(3, 1'b1, 8'h7F);

    // exact match, data acknowledged, flag cleared in between
    start_c("R10");
    frame(8'hA0, 1'b1, "R3");
    frame(8'h3C, 1'b0, "R8");
    ctl_clr(7'h08, "R7");
    frame(8'hC3, 1'b0, "R9");
    stop_c("R10");

    // masked match with priority, then NACK ends the transfer
    ctl_clr(7'h08, "R7");
    start_c("R10");
    frame(8'h6A, 1'b1, "R3");
    ctl_clr(7'h04, "R9");
    frame(8'h5A, 1'b0, "R9");
    frame(8'h77, 1'b0, "R9");
    stop_c("R10");
    ctl_set(7'h04, "R6");
    ctl_clr(7'h08, "R7");

    // read direction never matches
    start_c("R5");
    frame(8'hA1, 1'b1, "R5");
    stop_c("R5");

    // fully masked slot, repeated START, general call
    start_c("R10");
    frame(8'hC0, 1'b1, "R3");
    frame(8'h11, 1'b0, "R8");
    start_c("R10");
    frame(8'h00, 1'b1, "R4");
    frame(8'h99, 1'b0, "R8");
    stop_c("R10");

    // general call disabled: mask of all ones must not let address zero in
    cfg(3, 1'b0, 8'h24);
    start_c("R4");
    frame(8'h00, 1'b1, "R4");
    stop_c("R4");

    // acknowledge disabled on the address
    ctl_clr(7'h04, "R6");
    start_c("R6");
    frame(8'hA0, 1'b1, "R6");
    stop_c("R6");
    ctl_set(7'h04, "R6");

    // interface disabled
    ctl_clr(7'h40, "R11");
    ctl_set(7'h10, "R11");
    start_c("R11");
    frame(8'hA0, 1'b1, "R11");
    stop_c("R11");
    ctl_set(7'h40, "R11");

    // abort while addressed
    start_c("R12");
    frame(8'hA0, 1'b1, "R12");
    @(negedge clk);
    ctl_set_we = 1'b1; ctl_wdata = 7'h10;
    @(negedge clk);
    ctl_set_we = 1'b0; ctl_wdata = '0;
    expect1("R12 abort reads 1", ctl_o[4], 1'b1);
    expect1("R12 still addressed", addressed_o, 1'b1);
    @(negedge clk);
    expect1("R12 abort cleared", ctl_o[4], 1'b0);
    expect1("R12 not addressed", addressed_o, 1'b0);
    m_addr = 1'b0;
    check("R12");
    stop_c("R12");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule